// File: doc/BRIEF.md
# Serial EEPROM Command and Write-Protect Engine

This block is the byte-level command engine of a small serial EEPROM of up to 512 eight-bit words. A serial front end, which is not part of this block, deserialises the input line. It passes in complete bytes as one-cycle strobes, along with one-cycle pulses that mark the start and the end of a select window. The engine decodes the first byte of each window as a command and gathers a read or write address whose ninth bit is carried inside the command byte. It then returns the next byte to shift out, together with a drive-enable that the front end uses for the output's high-impedance control.

Writes pass three gates: a write-enable latch, a two-bit block-protection field in the status register, and an active-low write-protect pin. Write data collects in a page buffer, and a self-timed internal cycle then copies it into a register-file array. The cycle length is set by the `WR_CYCLES` parameter and stands in for the up-to-10 ms programming time. No erase step precedes a write. While the cycle runs, the engine accepts only the status read.

Top module: `eeprom_cmd_ctrl`

## Requirements
- R1: After reset the status byte reads 0x00, every array word reads 0x00, `tx_drive` is low and `wr_busy` is low.
- R2: Command 0x06 sets the enable latch and command 0x04 clears it. The status byte shows the latch in bit 1, the busy flag in bit 0 and the protection field in bits 3:2, and reads 0 in its other bits. Command 0x05 returns the status byte on every following byte slot.
- R3: Command `0000_A011` (A = address bit 8), followed by an address byte, returns the addressed word with `tx_drive` high. Each further byte slot returns the next word, and the address wraps from 0x1FF to 0x000.
- R4: Command `0000_A010`, followed by an address byte and data bytes, buffers the data within an 8-byte page whose low three address bits wrap. The timed cycle starts at the end of the select window, and only the received locations change.
- R5: A data write or status write that ends while the enable latch is clear starts no cycle and changes nothing.
- R6: The protection field (status bits 3:2) refuses writes to no page (00), to addresses 0x180–0x1FF (01), to 0x100–0x1FF (10), or to the whole array (11). A refused write leaves the enable latch set.
- R7: If `wp_n` is low at any point between the command byte of a write and the end of its select window, the write is cancelled.
- R8: Once the timed cycle has begun, `wp_n` has no effect on it.
- R9: The cycle lasts exactly `WR_CYCLES` clocks. During it, status reads show bit 0 set together with the latch, and every command other than 0x05 is ignored with `tx_drive` low.
- R10: The enable latch clears when a write cycle completes.
- R11: An unknown command byte turns off `tx_drive`, and all further bytes are ignored until the next start pulse.
- R12: If a select window ends with a partial byte (`part_byte` high), no cycle starts.
- R13: Command 0x01 followed by one byte writes only bits 3:2 of that byte into the protection field, and does so through a timed cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_fall | input | 1 | One-cycle pulse: select window opens |
| sel_rise | input | 1 | One-cycle pulse: select window closes |
| part_byte | input | 1 | Qualifies `sel_rise`: a partial byte was in flight |
| rx_valid | input | 1 | One-cycle strobe: `rx_byte` holds a complete byte |
| rx_byte | input | 8 | Received byte, MSB first assembled by the front end |
| wp_n | input | 1 | Hardware write protect, active low |
| tx_byte | output | 8 | Byte to shift out in the next byte slot |
| tx_drive | output | 1 | Output drive enable; low means high impedance |
| wr_busy | output | 1 | Internal write cycle in progress |

## Verification
Writes are tried at a mid-page start, at a start near a page end so that the lane index wraps, and at the last address with a read running across the top of the array. Together these separate page-wrap handling from array-wrap handling. Each protection setting is tried at an address just inside its refused region and at one just below it, so that an off-by-one boundary or a swapped field encoding shows. The write-protect pin is pulsed mid-command, held low at the end of the window, and dropped during a running cycle, which distinguishes cancellation from inhibition. Unknown commands, partial-byte endings and commands issued while busy check that rejected input leaves both the outputs and the stored state untouched.

// File: rtl/eeprom_cmd_pkg.sv
package eeprom_cmd_pkg;

   localparam logic [7:0] OPC_LATCH_SET = 8'h06;
   localparam logic [7:0] OPC_LATCH_CLR = 8'h04;
   localparam logic [7:0] OPC_STAT_RD   = 8'h05;
   localparam logic [7:0] OPC_STAT_WR   = 8'h01;
   localparam logic [2:0] OPC_RD_TAIL   = 3'b011;
   localparam logic [2:0] OPC_WR_TAIL   = 3'b010;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_OPC,
      ST_RADDR,
      ST_RDATA,
      ST_WADDR,
      ST_WDATA,
      ST_SRD,
      ST_SWR,
      ST_SWR_DONE,
      ST_IGNORE
   } cmd_state_t;

   typedef enum logic {
      CYC_ARRAY,
      CYC_STATUS
   } cyc_kind_t;

   function automatic logic is_mem_cmd(input logic [7:0] b, input logic [2:0] tail);
      return (b[7:4] == 4'b0000) && (b[2:0] == tail);
   endfunction

endpackage

// File: rtl/eeprom_wtimer.sv
module eeprom_wtimer #(
   parameter int unsigned CYCLES = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic done
);
   localparam int unsigned CNT_W = $clog2(CYCLES + 1);

   logic [CNT_W-1:0] cnt;

   initial begin
      if (CYCLES < 2) $fatal(1, "eeprom_wtimer: CYCLES must be at least 2");
   end

   assign done = busy && (cnt == CNT_W'(CYCLES - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cnt  <= '0;
      end else if (done) begin
         busy <= 1'b0;
         cnt  <= '0;
      end else if (start && !busy) begin
         busy <= 1'b1;
         cnt  <= '0;
      end else if (busy) begin
         cnt  <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/eeprom_guard.sv
module eeprom_guard #(
   parameter int unsigned ADDR_W = 9,
   parameter int unsigned PAGE_W = 3
) (
   input  logic [1:0]               bp,
   input  logic [ADDR_W-PAGE_W-1:0] page,
   output logic                     blocked
);
   localparam int unsigned PG_W = ADDR_W - PAGE_W;

   initial begin
      if (PG_W < 2) $fatal(1, "eeprom_guard: need at least four pages");
   end

   always_comb begin
      unique case (bp)
         2'b00:   blocked = 1'b0;
         2'b01:   blocked = (page[PG_W-1 -: 2] == 2'b11);
         2'b10:   blocked = page[PG_W-1];
         default: blocked = 1'b1;
      endcase
   end
endmodule

// File: rtl/eeprom_store.sv
module eeprom_store #(
   parameter int unsigned ADDR_W = 9,
   parameter int unsigned PAGE_W = 3,
   parameter int unsigned DATA_W = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     clr_lanes,
   input  logic                     ld,
   input  logic [PAGE_W-1:0]        ld_lane,
   input  logic [DATA_W-1:0]        ld_data,
   input  logic                     commit,
   input  logic [ADDR_W-PAGE_W-1:0] commit_page,
   input  logic [ADDR_W-1:0]        rd_addr,
   output logic [DATA_W-1:0]        rd_data
);
   localparam int unsigned DEPTH = 1 << ADDR_W;
   localparam int unsigned LANES = 1 << PAGE_W;

   logic [DATA_W-1:0] mem    [DEPTH];
   logic [DATA_W-1:0] lane_q [LANES];
   logic [LANES-1:0]  lane_v;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [DATA_W-1:0] q;
      logic              v;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q <= '0;
            v <= 1'b0;
         end else if (clr_lanes) begin
            v <= 1'b0;
         end else if (ld && (ld_lane == PAGE_W'(g))) begin
            q <= ld_data;
            v <= 1'b1;
         end
      end
      assign lane_q[g] = q;
      assign lane_v[g] = v;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (commit) begin
         for (int i = 0; i < LANES; i++) begin
            if (lane_v[i]) mem[{commit_page, PAGE_W'(i)}] <= lane_q[i];
         end
      end
   end

   assign rd_data = mem[rd_addr];
endmodule

// File: rtl/eeprom_cmd_ctrl.sv
module eeprom_cmd_ctrl
   import eeprom_cmd_pkg::*;
#(
   parameter int unsigned ADDR_W     = 9,
   parameter int unsigned PAGE_BYTES = 8,
   parameter int unsigned WR_CYCLES  = 64
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sel_fall,
   input  logic       sel_rise,
   input  logic       part_byte,
   input  logic       rx_valid,
   input  logic [7:0] rx_byte,
   input  logic       wp_n,
   output logic [7:0] tx_byte,
   output logic       tx_drive,
   output logic       wr_busy
);
   localparam int unsigned PAGE_W = $clog2(PAGE_BYTES);
   localparam int unsigned PG_W   = ADDR_W - PAGE_W;

   initial begin
      if (ADDR_W < 7 || ADDR_W > 9) $fatal(1, "eeprom_cmd_ctrl: ADDR_W must be 7..9");
      if (PAGE_BYTES < 2 || (1 << PAGE_W) != PAGE_BYTES)
         $fatal(1, "eeprom_cmd_ctrl: PAGE_BYTES must be a power of two >= 2");
   end

   cmd_state_t        state;
   cyc_kind_t         kind;
   logic              wel;
   logic [1:0]        bp;
   logic [1:0]        bp_next;
   logic              cancel;
   logic              got_data;
   logic              a8;
   logic [ADDR_W-1:0] cur_addr;
   logic [ADDR_W-1:0] full_addr;
   logic [ADDR_W-1:0] rd_addr;
   logic [PAGE_W-1:0] lane;
   logic [PG_W-1:0]   page_q;
   logic [7:0]        rd_data;
   logic [7:0]        status;
   logic              blocked;
   logic              done;
   logic              start;
   logic              in_window;
   logic              wr_gate;

   // Address assembly: the ninth bit comes from the command byte
   if (ADDR_W == 9) begin : g_addr9
      assign full_addr = {a8, rx_byte};
   end else if (ADDR_W == 8) begin : g_addr8
      assign full_addr = rx_byte;
   end else begin : g_addr_small
      assign full_addr = rx_byte[ADDR_W-1:0];
   end

   assign status    = {4'b0000, bp, wel, wr_busy};
   assign rd_addr   = (state == ST_RADDR) ? full_addr : cur_addr + 1'b1;
   assign in_window = !sel_fall && !sel_rise;

   assign wr_gate = wel && wp_n && !cancel && !part_byte && !wr_busy;
   assign start   = sel_rise && !sel_fall && wr_gate &&
                    (((state == ST_WDATA) && got_data && !blocked) ||
                     (state == ST_SWR_DONE));

   eeprom_wtimer #(.CYCLES(WR_CYCLES)) i_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .busy  (wr_busy),
      .done  (done)
   );

   eeprom_guard #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) i_guard (
      .bp      (bp),
      .page    (page_q),
      .blocked (blocked)
   );

   eeprom_store #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DATA_W(8)) i_store (
      .clk         (clk),
      .rst_n       (rst_n),
      .clr_lanes   (in_window && rx_valid && (state == ST_WADDR)),
      .ld          (in_window && rx_valid && (state == ST_WDATA)),
      .ld_lane     (lane),
      .ld_data     (rx_byte),
      .commit      (done && (kind == CYC_ARRAY)),
      .commit_page (page_q),
      .rd_addr     (rd_addr),
      .rd_data     (rd_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         kind     <= CYC_ARRAY;
         wel      <= 1'b0;
         bp       <= 2'b00;
         bp_next  <= 2'b00;
         cancel   <= 1'b0;
         got_data <= 1'b0;
         a8       <= 1'b0;
         cur_addr <= '0;
         lane     <= '0;
         page_q   <= '0;
         tx_byte  <= '0;
         tx_drive <= 1'b0;
      end else begin
         if (done) begin
            wel <= 1'b0;
            if (kind == CYC_STATUS) bp <= bp_next;
         end
         if (start) kind <= (state == ST_SWR_DONE) ? CYC_STATUS : CYC_ARRAY;

         if (sel_fall) begin
            state    <= ST_OPC;
            cancel   <= 1'b0;
            got_data <= 1'b0;
            tx_drive <= 1'b0;
         end else if (sel_rise) begin
            state    <= ST_IDLE;
            tx_drive <= 1'b0;
         end else begin
            if (!wp_n && (state inside {ST_WADDR, ST_WDATA, ST_SWR, ST_SWR_DONE}))
               cancel <= 1'b1;
            if (rx_valid) begin
               unique case (state)
                  ST_OPC: begin
                     if (rx_byte == OPC_STAT_RD) begin
                        state    <= ST_SRD;
                        tx_byte  <= status;
                        tx_drive <= 1'b1;
                     end else if (wr_busy) begin
                        state    <= ST_IGNORE;
                     end else if (rx_byte == OPC_LATCH_SET) begin
                        wel      <= 1'b1;
                        state    <= ST_IGNORE;
                     end else if (rx_byte == OPC_LATCH_CLR) begin
                        wel      <= 1'b0;
                        state    <= ST_IGNORE;
                     end else if (rx_byte == OPC_STAT_WR) begin
                        state    <= ST_SWR;
                     end else if (is_mem_cmd(rx_byte, OPC_RD_TAIL)) begin
                        a8       <= rx_byte[3];
                        state    <= ST_RADDR;
                     end else if (is_mem_cmd(rx_byte, OPC_WR_TAIL)) begin
                        a8       <= rx_byte[3];
                        state    <= ST_WADDR;
                     end else begin
                        state    <= ST_IGNORE;
                     end
                  end
                  ST_RADDR: begin
                     cur_addr <= full_addr;
                     tx_byte  <= rd_data;
                     tx_drive <= 1'b1;
                     state    <= ST_RDATA;
                  end
                  ST_RDATA: begin
                     cur_addr <= cur_addr + 1'b1;
                     tx_byte  <= rd_data;
                  end
                  ST_WADDR: begin
                     cur_addr <= full_addr;
                     lane     <= full_addr[PAGE_W-1:0];
                     page_q   <= full_addr[ADDR_W-1:PAGE_W];
                     state    <= ST_WDATA;
                  end
                  ST_WDATA: begin
                     lane     <= lane + 1'b1;
                     got_data <= 1'b1;
                  end
                  ST_SRD: begin
                     tx_byte  <= status;
                  end
                  ST_SWR: begin
                     bp_next  <= rx_byte[3:2];
                     state    <= ST_SWR_DONE;
                  end
                  default: ;
               endcase
            end
         end
      end
   end
endmodule

// File: rtl/eeprom_cmd_ctrl_chk.sv
module eeprom_cmd_ctrl_chk
   import eeprom_cmd_pkg::*;
#(
   parameter int unsigned WR_CYCLES = 64
) (
   input logic       clk,
   input logic       rst_n,
   input logic       sel_rise,
   input logic       wp_n,
   input logic       tx_drive,
   input logic       wr_busy,
   input logic       wel,
   input cmd_state_t state
);
   int unsigned run_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       run_cnt <= 0;
      else if (wr_busy) run_cnt <= run_cnt + 1;
      else              run_cnt <= 0;
   end

   p_drive_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
      sel_rise |=> !tx_drive);

   p_start_on_close_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wr_busy) |-> $past(sel_rise));

   p_start_needs_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wr_busy) |-> $past(wel));

   p_start_needs_pin_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wr_busy) |-> $past(wp_n));

   p_latch_cleared_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wr_busy) |-> !wel);

   p_cycle_length_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wr_busy) |-> (run_cnt == WR_CYCLES));

   p_busy_blocks_access_r9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_busy |-> !(state inside {ST_RADDR, ST_RDATA, ST_WADDR, ST_WDATA, ST_SWR}));
endmodule

bind eeprom_cmd_ctrl eeprom_cmd_ctrl_chk #(.WR_CYCLES(WR_CYCLES)) i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .sel_rise (sel_rise),
   .wp_n     (wp_n),
   .tx_drive (tx_drive),
   .wr_busy  (wr_busy),
   .wel      (wel),
   .state    (state)
);

// File: tb/test_eeprom_cmd_ctrl.sv
module test_eeprom_cmd_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sel_fall = 1'b0;
   logic       sel_rise = 1'b0;
   logic       part_byte = 1'b0;
   logic       rx_valid = 1'b0;
   logic [7:0] rx_byte = 8'h00;
   logic       wp_n = 1'b1;
   logic [7:0] tx_byte;
   logic       tx_drive;
   logic       wr_busy;

   int n_checks = 0;
   int n_errors = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   eeprom_cmd_ctrl #(.ADDR_W(9), .PAGE_BYTES(8), .WR_CYCLES(64)) i_eeprom_cmd_ctrl (
      .clk(clk), .rst_n(rst_n), .sel_fall(sel_fall), .sel_rise(sel_rise),
      .part_byte(part_byte), .rx_valid(rx_valid), .rx_byte(rx_byte), .wp_n(wp_n),
      .tx_byte(tx_byte), .tx_drive(tx_drive), .wr_busy(wr_busy)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic open_win();
      sel_fall = 1'b1;
      @(negedge clk);
      sel_fall = 1'b0;
   endtask

   task automatic close_win(input logic frag);
      sel_rise = 1'b1;
      part_byte = frag;
      @(negedge clk);
      sel_rise = 1'b0;
      part_byte = 1'b0;
   endtask

   task automatic xfer(input logic [7:0] b, output logic [7:0] t, output logic d);
      rx_valid = 1'b1;
      rx_byte = b;
      @(negedge clk);
      rx_valid = 1'b0;
      t = tx_byte;
      d = tx_drive;
   endtask

   task automatic simple_cmd(input logic [7:0] op);
      logic [7:0] t;
      logic d;
      open_win();
      xfer(op, t, d);
      close_win(1'b0);
   endtask

   task automatic rd_status(output logic [7:0] s);
      logic d;
      open_win();
      xfer(8'h05, s, d);
      close_win(1'b0);
   endtask

   task automatic rd_byte(input logic [8:0] a, output logic [7:0] v);
      logic [7:0] t;
      logic d;
      open_win();
      xfer({4'b0000, a[8], 3'b011}, t, d);
      xfer(a[7:0], v, d);
      close_win(1'b0);
   endtask

   task automatic wait_ready();
      for (int i = 0; i < 400 && wr_busy; i++) @(negedge clk);
   endtask

   task automatic wr_bytes(input logic [8:0] a, input int n, input logic [7:0] b0,
                           input logic [7:0] b1, input logic [7:0] b2, input logic frag);
      logic [7:0] t;
      logic d;
      logic [7:0] bl [3];
      bl[0] = b0; bl[1] = b1; bl[2] = b2;
      open_win();
      xfer({4'b0000, a[8], 3'b010}, t, d);
      xfer(a[7:0], t, d);
      for (int i = 0; i < n; i++) xfer(bl[i], t, d);
      close_win(frag);
   endtask

   task automatic set_bp(input logic [7:0] v);
      logic [7:0] t;
      logic d;
      simple_cmd(8'h06);
      open_win();
      xfer(8'h01, t, d);
      xfer(v, t, d);
      close_win(1'b0);
      wait_ready();
   endtask

   task automatic t_reset();
      logic [7:0] v;
      chk("R1 tx_drive idle", {7'b0, tx_drive}, 8'h00);
      chk("R1 busy idle", {7'b0, wr_busy}, 8'h00);
      rd_status(v);
      chk("R1 status", v, 8'h00);
      rd_byte(9'h155, v);
      chk("R1 array word", v, 8'h00);
   endtask

   task automatic t_latch();
      logic [7:0] v;
      logic [7:0] t;
      logic d;
      simple_cmd(8'h06);
      rd_status(v);
      chk("R2 latch set", v, 8'h02);
      open_win();
      xfer(8'h05, t, d);
      xfer(8'h00, v, d);
      close_win(1'b0);
      chk("R2 repeated status", v, 8'h02);
      chk("R2 status drive", {7'b0, d}, 8'h01);
      simple_cmd(8'h04);
      rd_status(v);
      chk("R2 latch clear", v, 8'h00);
   endtask

   task automatic t_write_basic();
      logic [7:0] v;
      logic [7:0] t;
      logic d;
      simple_cmd(8'h06);
      wr_bytes(9'h105, 2, 8'hAA, 8'hBB, 8'h00, 1'b0);
      chk("R4 cycle started", {7'b0, wr_busy}, 8'h01);
      rd_status(v);
      chk("R9 busy status", v, 8'h03);
      open_win();
      xfer(8'h03, t, d);
      xfer(8'h05, t, d);
      close_win(1'b0);
      chk("R9 read ignored while busy", {7'b0, d}, 8'h00);
      wait_ready();
      rd_status(v);
      chk("R10 latch cleared after write", v, 8'h00);
      rd_byte(9'h105, v);
      chk("R3 read first byte", v, 8'hAA);
      rd_byte(9'h106, v);
      chk("R4 second byte", v, 8'hBB);
      rd_byte(9'h104, v);
      chk("R4 neighbour untouched", v, 8'h00);
   endtask

   task automatic t_page_wrap();
      logic [7:0] v;
      simple_cmd(8'h06);
      wr_bytes(9'h00E, 3, 8'h11, 8'h22, 8'h33, 1'b0);
      wait_ready();
      rd_byte(9'h00E, v);
      chk("R4 lane 6", v, 8'h11);
      rd_byte(9'h00F, v);
      chk("R4 lane 7", v, 8'h22);
      rd_byte(9'h008, v);
      chk("R4 wrapped lane 0", v, 8'h33);
      rd_byte(9'h010, v);
      chk("R4 next page untouched", v, 8'h00);
   endtask

   task automatic t_read_wrap();
      logic [7:0] v;
      logic [7:0] t;
      logic d;
      simple_cmd(8'h06);
      wr_bytes(9'h1FF, 1, 8'h5A, 8'h00, 8'h00, 1'b0);
      wait_ready();
      simple_cmd(8'h06);
      wr_bytes(9'h000, 1, 8'hC3, 8'h00, 8'h00, 1'b0);
      wait_ready();
      open_win();
      xfer(8'h0B, t, d);
      xfer(8'hFF, v, d);
      chk("R3 read top word", v, 8'h5A);
      xfer(8'h00, v, d);
      chk("R3 wrap to zero", v, 8'hC3);
      xfer(8'h00, v, d);
      chk("R3 increment to one", v, 8'h00);
      chk("R3 drive during read", {7'b0, d}, 8'h01);
      close_win(1'b0);
   endtask

   task automatic t_no_latch();
      logic [7:0] v;
      wr_bytes(9'h020, 1, 8'h77, 8'h00, 8'h00, 1'b0);
      chk("R5 no cycle without latch", {7'b0, wr_busy}, 8'h00);
      rd_byte(9'h020, v);
      chk("R5 data unchanged", v, 8'h00);
      open_win();
      rx_valid = 1'b1; rx_byte = 8'h01; @(negedge clk);
      rx_byte = 8'h0C; @(negedge clk);
      rx_valid = 1'b0;
      close_win(1'b0);
      chk("R5 status write refused", {7'b0, wr_busy}, 8'h00);
   endtask

   task automatic t_protect();
      logic [7:0] v;
      set_bp(8'hF5);
      rd_status(v);
      chk("R13 only field bits kept", v, 8'h04);
      simple_cmd(8'h06);
      wr_bytes(9'h180, 1, 8'hE1, 8'h00, 8'h00, 1'b0);
      chk("R6 quarter refused", {7'b0, wr_busy}, 8'h00);
      rd_status(v);
      chk("R6 latch kept after refusal", v, 8'h06);
      wr_bytes(9'h17F, 1, 8'hE2, 8'h00, 8'h00, 1'b0);
      wait_ready();
      rd_byte(9'h17F, v);
      chk("R6 below quarter allowed", v, 8'hE2);
      rd_byte(9'h180, v);
      chk("R6 quarter untouched", v, 8'h00);
      set_bp(8'h08);
      simple_cmd(8'h06);
      wr_bytes(9'h100, 1, 8'hE3, 8'h00, 8'h00, 1'b0);
      chk("R6 half refused", {7'b0, wr_busy}, 8'h00);
      wr_bytes(9'h0F0, 1, 8'hE4, 8'h00, 8'h00, 1'b0);
      wait_ready();
      rd_byte(9'h0F0, v);
      chk("R6 below half allowed", v, 8'hE4);
      set_bp(8'h0C);
      simple_cmd(8'h06);
      wr_bytes(9'h030, 1, 8'hE5, 8'h00, 8'h00, 1'b0);
      chk("R6 whole array refused", {7'b0, wr_busy}, 8'h00);
      set_bp(8'h00);
      rd_status(v);
      chk("R13 field cleared", v, 8'h00);
   endtask

   task automatic t_wp();
      logic [7:0] v;
      logic [7:0] t;
      logic d;
      simple_cmd(8'h06);
      open_win();
      xfer(8'h02, t, d);
      xfer(8'h40, t, d);
      wp_n = 1'b0; @(negedge clk); wp_n = 1'b1;
      xfer(8'h77, t, d);
      close_win(1'b0);
      chk("R7 pulse cancels", {7'b0, wr_busy}, 8'h00);
      wp_n = 1'b0;
      wr_bytes(9'h041, 1, 8'h78, 8'h00, 8'h00, 1'b0);
      chk("R7 low pin inhibits", {7'b0, wr_busy}, 8'h00);
      wp_n = 1'b1;
      rd_byte(9'h040, v);
      chk("R7 word unchanged", v, 8'h00);
      rd_byte(9'h041, v);
      chk("R7 word unchanged 2", v, 8'h00);
      wr_bytes(9'h048, 1, 8'h99, 8'h00, 8'h00, 1'b0);
      chk("R8 cycle started", {7'b0, wr_busy}, 8'h01);
      wp_n = 1'b0;
      wait_ready();
      wp_n = 1'b1;
      rd_byte(9'h048, v);
      chk("R8 write completed", v, 8'h99);
   endtask

   task automatic t_invalid();
      logic [7:0] v;
      logic [7:0] t;
      logic d;
      open_win();
      xfer(8'hFF, t, d);
      chk("R11 no drive after unknown", {7'b0, d}, 8'h00);
      xfer(8'h06, t, d);
      xfer(8'h05, t, d);
      chk("R11 later bytes ignored", {7'b0, d}, 8'h00);
      close_win(1'b0);
      rd_status(v);
      chk("R11 latch not set", v, 8'h00);
   endtask

   task automatic t_partial();
      logic [7:0] v;
      simple_cmd(8'h06);
      wr_bytes(9'h030, 1, 8'h5C, 8'h00, 8'h00, 1'b1);
      chk("R12 no cycle on partial byte", {7'b0, wr_busy}, 8'h00);
      rd_byte(9'h030, v);
      chk("R12 data unchanged", v, 8'h00);
      simple_cmd(8'h04);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_latch();
      t_write_basic();
      t_page_wrap();
      t_read_wrap();
      t_no_latch();
      t_protect();
      t_wp();
      t_invalid();
      t_partial();
      finished = 1'b1;
   end

   initial begin
      for (int i = 0; i < 150000 && !finished; i++) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual running expected finished");
      end
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end
endmodule